// File: doc/BRIEF.md
# Fetch Stage Cycle Controller

This block decides, once per clock, whether the instruction fetch stage of a pipelined processor may issue a fetch. It takes redirect requests from commit and from decode, each carrying a new program counter. It also takes a flag saying the reorder buffer is still being flushed, stall flags from four downstream stages, the instruction cache miss response and miss completion pulse, and a fetch fault flag. The requests are resolved in a fixed priority. The block holds the current and next program counter, which change only on an applied redirect. It also drives predictor squash and update strobes, a cancel for an outstanding cache miss, and three saturating event counters.

The block issues at most one fetch per cycle through a registered `fetch_en`. A fetch requested in cycle t is performed in cycle t+1. The cache answers that fetch through `miss_in` or `fault_in` in the same cycle t+1. When `fetch_replay` is high with `fetch_en`, the fetch consumes the line that a completed miss already returned, so no new cache request is made and `miss_in`/`fault_in` are not looked at.

Top module: `fetch_ctrl`

## Requirements
- R1: After reset the state is Idle (code 0) and `fetch_en` and `fetch_replay` are 0. `pc` equals RESET_PC, `next_pc` equals RESET_PC plus INST_BYTES, and all counters are 0.
- R2: A commit squash overrides every other input. In the same cycle it pulses `pred_squash`, with `pred_squash_seq` set to `cmt_seq`, and `pred_update` stays 0. On the next edge `pc` becomes `cmt_pc`, `next_pc` becomes `cmt_pc` plus INST_BYTES, and the state becomes Squashing (code 2). No fetch is requested.
- R3: Without a commit squash, a nonzero `cmt_seq` pulses `pred_update` in the same cycle, with `pred_update_seq` equal to `cmt_seq`.
- R4: With `rob_squashing` high and no commit squash, the state becomes Squashing and the squash counter advances. No fetch is requested, and a decode squash in that cycle has no effect: no predictor squash and no PC change.
- R5: A decode squash below R2 and R4 always pulses `pred_squash`, with `pred_squash_seq` set to `dec_seq`. It redirects `pc` to `dec_pc` and enters Squashing only when the state is not already Squashing.
- R6: When no squash takes effect and any bit of `stall_in` is high, the state becomes Blocked (code 3), from any state. A blocked cycle is counted and no fetch is requested.
- R7: In Blocked with all stall bits low, the state becomes Running (code 1) but no fetch is requested that cycle, and the cycle is counted as blocked. The next quiet cycle requests a fetch.
- R8: In Squashing with no squash or stall input active, the state becomes Running and a fetch is requested in that same cycle.
- R9: `miss_in` during a non-replay fetch moves the state to miss-wait (code 4), where no fetch is requested. `miss_done` there moves it to miss-complete (code 5). The next cycle requests a fetch with `fetch_replay` high and returns to Running, and a `miss_in` during that replay fetch is ignored.
- R10: `fault_in` during a non-replay fetch, with no miss, moves the state to Blocked without requesting a fetch.
- R11: A redirect applied while a miss is outstanding (state miss-wait, or `miss_in` during the current fetch) pulses `miss_cancel` in the same cycle. A later `miss_done` then has no effect.
- R12: The squash, blocked and fetch counters each stop at their all-ones value instead of wrapping.
- R13: From Idle with no other event, a fetch is requested and the state becomes Running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_squash | input | 1 | Redirect request from commit |
| cmt_pc | input | ADDR_W | Redirect target from commit |
| cmt_seq | input | SEQ_W | Completed sequence number from commit, 0 means none |
| rob_squashing | input | 1 | Reorder buffer still flushing |
| dec_squash | input | 1 | Redirect request from decode |
| dec_pc | input | ADDR_W | Redirect target from decode |
| dec_seq | input | SEQ_W | Sequence number of the decode redirect |
| stall_in | input | 4 | Stall flags from four downstream stages |
| miss_in | input | 1 | Cache miss for the fetch performed this cycle |
| miss_done | input | 1 | Outstanding miss has completed |
| fault_in | input | 1 | Non-miss fault for the fetch performed this cycle |
| fetch_en | output | 1 | Perform a fetch this cycle (registered) |
| fetch_replay | output | 1 | This fetch uses the already returned line |
| pc | output | ADDR_W | Current fetch program counter |
| next_pc | output | ADDR_W | Program counter plus instruction size |
| miss_cancel | output | 1 | Cancel the outstanding cache miss |
| pred_squash | output | 1 | Predictor squash strobe |
| pred_squash_seq | output | SEQ_W | Sequence number for the predictor squash |
| pred_update | output | 1 | Predictor update strobe |
| pred_update_seq | output | SEQ_W | Sequence number for the predictor update |
| state | output | 3 | Controller state code |
| cnt_squash | output | CNT_W | Squash cycle counter |
| cnt_blocked | output | CNT_W | Blocked cycle counter |
| cnt_fetch | output | CNT_W | Fetch request counter |

## Verification
The bench goes after the exits from non-running states. If the Blocked exit rule were missing, `fetch_en` would rise one cycle early after a stall. If the Squashing exit were merged with it, the same-cycle fetch after a squash would be lost. It checks that a decode squash arriving during Squashing or during a reorder-buffer flush leaves the PC alone, and that a commit squash masks a simultaneous predictor update. It also checks that a `miss_done` after a cancelling redirect does not push the controller into miss-complete, and that a `miss_in` during a replay fetch is ignored; a design that got this wrong would stall forever on the replayed line. A narrow counter width drives two counters into saturation, where a wrapping counter would read back small values.

// File: rtl/fetch_ctrl.sv
module fetch_ctrl #(
  parameter int ADDR_W = 32,
  parameter int SEQ_W = 16,
  parameter int CNT_W = 16,
  parameter int INST_BYTES = 4,
  parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmt_squash,
  input  logic [ADDR_W-1:0] cmt_pc,
  input  logic [SEQ_W-1:0]  cmt_seq,
  input  logic              rob_squashing,
  input  logic              dec_squash,
  input  logic [ADDR_W-1:0] dec_pc,
  input  logic [SEQ_W-1:0]  dec_seq,
  input  logic [3:0]        stall_in,
  input  logic              miss_in,
  input  logic              miss_done,
  input  logic              fault_in,
  output logic              fetch_en,
  output logic              fetch_replay,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] next_pc,
  output logic              miss_cancel,
  output logic              pred_squash,
  output logic [SEQ_W-1:0]  pred_squash_seq,
  output logic              pred_update,
  output logic [SEQ_W-1:0]  pred_update_seq,
  output logic [2:0]        state,
  output logic [CNT_W-1:0]  cnt_squash,
  output logic [CNT_W-1:0]  cnt_blocked,
  output logic [CNT_W-1:0]  cnt_fetch
);
  typedef enum logic [2:0] {
    S_IDLE = 3'd0, S_RUN = 3'd1, S_SQ = 3'd2, S_BLK = 3'd3, S_MISS = 3'd4, S_DONE = 3'd5
  } st_t;

  localparam logic [ADDR_W-1:0] INST_INC = ADDR_W'(INST_BYTES);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  st_t state_q, state_d;
  logic go, rep, redir, inc_sq, inc_blk;
  logic [ADDR_W-1:0] rpc;

  wire any_stall  = |stall_in;
  wire resp_miss  = fetch_en & ~fetch_replay & miss_in;
  wire resp_fault = fetch_en & ~fetch_replay & fault_in;

  always_comb begin
    state_d = state_q;
    go = 1'b0;
    rep = 1'b0;
    redir = 1'b0;
    rpc = cmt_pc;
    pred_squash = 1'b0;
    pred_squash_seq = cmt_seq;
    inc_sq = 1'b0;
    inc_blk = 1'b0;
    if (cmt_squash) begin
      state_d = S_SQ;
      redir = 1'b1;
      pred_squash = 1'b1;
      inc_sq = 1'b1;
    end else if (rob_squashing) begin
      state_d = S_SQ;
      inc_sq = 1'b1;
    end else if (dec_squash && state_q != S_SQ) begin
      state_d = S_SQ;
      redir = 1'b1;
      rpc = dec_pc;
      pred_squash = 1'b1;
      pred_squash_seq = dec_seq;
      inc_sq = 1'b1;
    end else begin
      if (dec_squash) begin
        pred_squash = 1'b1;
        pred_squash_seq = dec_seq;
      end
      if (any_stall) begin
        state_d = S_BLK;
        inc_blk = 1'b1;
      end else if (state_q == S_BLK) begin
        state_d = S_RUN;
        inc_blk = 1'b1;
      end else if (resp_miss) begin
        state_d = S_MISS;
      end else if (resp_fault) begin
        state_d = S_BLK;
      end else begin
        case (state_q)
          S_MISS: if (miss_done) state_d = S_DONE;
          S_DONE: begin go = 1'b1; rep = 1'b1; state_d = S_RUN; end
          default: begin go = 1'b1; state_d = S_RUN; end
        endcase
      end
    end
  end

  assign pred_update     = ~cmt_squash & (|cmt_seq);
  assign pred_update_seq = cmt_seq;
  assign miss_cancel     = redir & ((state_q == S_MISS) | resp_miss);
  assign state           = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      fetch_en     <= 1'b0;
      fetch_replay <= 1'b0;
      pc           <= RESET_PC;
      next_pc      <= RESET_PC + INST_INC;
      cnt_squash   <= '0;
      cnt_blocked  <= '0;
      cnt_fetch    <= '0;
    end else begin
      state_q      <= state_d;
      fetch_en     <= go;
      fetch_replay <= rep;
      if (redir) begin
        pc      <= rpc;
        next_pc <= rpc + INST_INC;
      end
      if (inc_sq && cnt_squash != CNT_MAX) cnt_squash <= cnt_squash + 1'b1;
      if (inc_blk && cnt_blocked != CNT_MAX) cnt_blocked <= cnt_blocked + 1'b1;
      if (go && cnt_fetch != CNT_MAX) cnt_fetch <= cnt_fetch + 1'b1;
    end
  end

  // R2
  cmt_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_squash |=> (state_q == S_SQ) && !fetch_en && (pc == $past(cmt_pc)) &&
                   (next_pc == $past(cmt_pc) + INST_INC));

  // R4
  rob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rob_squashing && !cmt_squash) |=> (state_q == S_SQ) && !fetch_en && $stable(pc));

  // R6
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmt_squash && !rob_squashing && !(dec_squash && state_q != S_SQ) && (stall_in != 4'd0))
      |=> (state_q == S_BLK) && !fetch_en);

  // R7
  block_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_BLK && !cmt_squash && !rob_squashing && !dec_squash && stall_in == 4'd0)
      |=> (state_q == S_RUN) && !fetch_en);

  // R9
  replay_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_replay |-> $past(state_q) == S_DONE);

  // R11
  cancel_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cancel |=> state_q == S_SQ);

  // R12
  squash_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_squash == CNT_MAX) |=> (cnt_squash == CNT_MAX));

  // R12
  fetch_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_fetch == CNT_MAX) |=> (cnt_fetch == CNT_MAX));
endmodule

// File: tb/tb_fetch_ctrl.sv
module tb_fetch_ctrl;
  localparam int PERIOD = 10;
  localparam int AW = 32;
  localparam int SW = 8;
  localparam int CW = 3;
  localparam int NV = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmt_squash = 0, rob_squashing = 0, dec_squash = 0;
  logic miss_in = 0, miss_done = 0, fault_in = 0;
  logic [AW-1:0] cmt_pc = 32'h1000, dec_pc = 32'h2000;
  logic [SW-1:0] cmt_seq = 0, dec_seq = 8'd9;
  logic [3:0] stall_in = 0;
  logic fetch_en, fetch_replay, miss_cancel, pred_squash, pred_update;
  logic [AW-1:0] pc, next_pc;
  logic [SW-1:0] pred_squash_seq, pred_update_seq;
  logic [2:0] state;
  logic [CW-1:0] cnt_squash, cnt_blocked, cnt_fetch;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  fetch_ctrl #(.ADDR_W(AW), .SEQ_W(SW), .CNT_W(CW), .INST_BYTES(4), .RESET_PC(32'h0)) dut (
    .clk(clk), .rst_n(rst_n), .cmt_squash(cmt_squash), .cmt_pc(cmt_pc), .cmt_seq(cmt_seq),
    .rob_squashing(rob_squashing), .dec_squash(dec_squash), .dec_pc(dec_pc), .dec_seq(dec_seq),
    .stall_in(stall_in), .miss_in(miss_in), .miss_done(miss_done), .fault_in(fault_in),
    .fetch_en(fetch_en), .fetch_replay(fetch_replay), .pc(pc), .next_pc(next_pc),
    .miss_cancel(miss_cancel), .pred_squash(pred_squash), .pred_squash_seq(pred_squash_seq),
    .pred_update(pred_update), .pred_update_seq(pred_update_seq), .state(state),
    .cnt_squash(cnt_squash), .cnt_blocked(cnt_blocked), .cnt_fetch(cnt_fetch));

  always #(PERIOD/2) clk = ~clk;

  // {tag, cs rob ds stall[3:0] miss done fault upd, state fe rp cancel psq pupd}
  localparam logic [22:0] VEC [NV] = '{
    {4'd13, 11'b000_0000_0000, 8'b001_1_0_0_0_0}, // R13 idle fetches
    {4'd13, 11'b000_0000_0000, 8'b001_1_0_0_0_0}, // R13
    {4'd3,  11'b000_0000_0001, 8'b001_1_0_0_0_1}, // R3 update
    {4'd9,  11'b000_0000_1000, 8'b100_0_0_0_0_0}, // R9 miss
    {4'd9,  11'b000_0000_0000, 8'b100_0_0_0_0_0}, // R9 wait
    {4'd9,  11'b000_0000_0100, 8'b101_0_0_0_0_0}, // R9 done
    {4'd9,  11'b000_0000_0000, 8'b001_1_1_0_0_0}, // R9 replay
    {4'd9,  11'b000_0000_1000, 8'b001_1_0_0_0_0}, // R9 miss ignored on replay
    {4'd6,  11'b000_0100_0000, 8'b011_0_0_0_0_0}, // R6 stall
    {4'd6,  11'b000_0100_0000, 8'b011_0_0_0_0_0}, // R6
    {4'd7,  11'b000_0000_0000, 8'b001_0_0_0_0_0}, // R7 dead cycle
    {4'd7,  11'b000_0000_0000, 8'b001_1_0_0_0_0}, // R7
    {4'd2,  11'b100_0000_0000, 8'b010_0_0_0_1_0}, // R2 commit squash
    {4'd4,  11'b010_0000_0000, 8'b010_0_0_0_0_0}, // R4 rob flush
    {4'd8,  11'b001_0000_0000, 8'b001_1_0_0_1_0}, // R8 exit with fetch, R5 seq only
    {4'd10, 11'b000_0000_0010, 8'b011_0_0_0_0_0}, // R10 fault
    {4'd7,  11'b000_0000_0000, 8'b001_0_0_0_0_0}, // R7
    {4'd7,  11'b000_0000_0000, 8'b001_1_0_0_0_0}, // R7
    {4'd9,  11'b000_0000_1000, 8'b100_0_0_0_0_0}, // R9
    {4'd11, 11'b001_0000_0000, 8'b010_0_0_1_1_0}, // R11 decode cancel
    {4'd11, 11'b000_0000_0100, 8'b001_1_0_0_0_0}, // R11 stale done ignored
    {4'd9,  11'b000_0000_1000, 8'b100_0_0_0_0_0}, // R9
    {4'd11, 11'b100_0000_0100, 8'b010_0_0_1_1_0}, // R11 commit cancel
    {4'd8,  11'b000_0000_0000, 8'b001_1_0_0_0_0}, // R8
    {4'd5,  11'b001_0000_0000, 8'b010_0_0_0_1_0}, // R5 decode redirect
    {4'd6,  11'b000_0001_0000, 8'b011_0_0_0_0_0}, // R6 from squashing
    {4'd2,  11'b100_1000_0000, 8'b010_0_0_0_1_0}, // R2 over stall
    {4'd2,  11'b100_0000_0001, 8'b010_0_0_0_1_0}, // R2 masks update
    {4'd4,  11'b011_0000_0000, 8'b010_0_0_0_0_0}, // R4 masks decode
    {4'd8,  11'b000_0000_0000, 8'b001_1_0_0_0_0}  // R8
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic clear_in();
    cmt_squash = 0; rob_squashing = 0; dec_squash = 0; stall_in = 0;
    miss_in = 0; miss_done = 0; fault_in = 0; cmt_seq = 0;
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(state == 3'd0, "R1", "state", state, 0);
    check(!fetch_en && !fetch_replay, "R1", "fetch", fetch_en, 0);
    check(pc == 32'h0 && next_pc == 32'h4, "R1", "pc", pc, 0);
    check(cnt_squash == 0 && cnt_blocked == 0 && cnt_fetch == 0, "R1", "counters",
          cnt_fetch, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [22:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", v[22:19], i);
      cmt_squash = v[18]; rob_squashing = v[17]; dec_squash = v[16];
      stall_in = v[15:12]; miss_in = v[11]; miss_done = v[10]; fault_in = v[9];
      cmt_seq = (v[18] | v[8]) ? 8'd7 : 8'd0;
      #1;
      check(miss_cancel == v[2], tg, "miss_cancel", miss_cancel, v[2]);
      check(pred_squash == v[1], tg, "pred_squash", pred_squash, v[1]);
      check(pred_update == v[0], tg, "pred_update", pred_update, v[0]);
      if (v[1]) check(pred_squash_seq == (v[18] ? 8'd7 : 8'd9), tg, "squash seq",
                      pred_squash_seq, v[18] ? 7 : 9);
      if (v[0]) check(pred_update_seq == 8'd7, tg, "update seq", pred_update_seq, 7);
      @(negedge clk);
      check(state == v[7:5], tg, "state", state, v[7:5]);
      check(fetch_en == v[4], tg, "fetch_en", fetch_en, v[4]);
      check(fetch_replay == v[3], tg, "fetch_replay", fetch_replay, v[3]);
      clear_in();
    end

    // R2 final redirect target; R4 decode during flush left pc alone
    check(pc == 32'h1000 && next_pc == 32'h1004, "R2", "pc after table", pc, 32'h1000);
    // R12 saturation: squash 8 and fetch 11 events clamp at 7, blocked 5
    check(cnt_squash == 3'd7, "R12", "cnt_squash", cnt_squash, 7);
    check(cnt_fetch == 3'd7, "R12", "cnt_fetch", cnt_fetch, 7);
    check(cnt_blocked == 3'd5, "R6", "cnt_blocked", cnt_blocked, 5);

    // R5 decode redirect ignored while squashing
    cmt_pc = 32'h40; cmt_squash = 1; cmt_seq = 8'd7;
    @(negedge clk); clear_in();
    check(pc == 32'h40 && next_pc == 32'h44, "R2", "pc redirect", pc, 32'h40);
    dec_pc = 32'h80; dec_squash = 1;
    @(negedge clk); clear_in();
    check(pc == 32'h40, "R5", "pc held in squashing", pc, 32'h40);
    check(state == 3'd1 && fetch_en, "R8", "exit fetch", state, 1);
    dec_squash = 1;
    @(negedge clk); clear_in();
    check(pc == 32'h80 && next_pc == 32'h84, "R5", "decode redirect", pc, 32'h80);
    check(state == 3'd2, "R5", "state", state, 2);

    finish_run();
  end
endmodule